// File: doc/BRIEF.md
# SD Card Clock Generator

This block derives the clock that is driven to an SD card from the controller's base clock. The division is done in two cascaded stages. The first is a power-of-two prescaler selectable from 2 to 256. The second is a linear divisor selectable from 1 to 16. The card clock period is the product of the two factors, with an even 50 % duty cycle.

A single write strobe loads an enable bit, a one-hot prescale select field and a divisor field. The frequency fields are taken only while the card clock is fully stopped; otherwise they are dropped, and the enable bit still takes effect. The output is gated only at the internal low phase, so that no shortened pulse reaches the card. Two status outputs are provided. One reports that the card clock is currently held off. The other reports that the frequency has settled after a reconfiguration.

Top module: `sdclk_gen`

## Requirements
- R1: While `rst_n` is low and right after reset, `sd_clk` is 0, `clk_off` is 1 and `clk_stable` is 0.
- R2: A prescale select code with only bit k set (bit 0 = LSB of `cfg_pre_sel`) selects a prescale factor of 2^(k+1), so bit 0 gives 2 and bit 7 gives 256.
- R3: A divisor field value v in `cfg_div_sel` selects a second-stage factor of v+1, from 1 (v=0) to 16 (v=15).
- R4: Once enabled, `sd_clk` has a period of P*D base clock cycles, where P is the prescale factor and D the divisor factor. It is high for P*D/2 cycles and low for P*D/2 cycles.
- R5: A prescale select code with no bit set or with more than one bit set is treated as a prescale factor of 2.
- R6: A write is applied to the frequency fields only when the enable is currently 0 and `clk_off` is 1. Any other write leaves the frequency and `clk_stable` unchanged, and its enable bit is still applied.
- R7: Every high pulse of `sd_clk` lasts exactly half the configured period. The first pulse after enabling is full length. A disable during a high pulse lets that pulse finish, and the output then stays low.
- R8: `clk_off` is 1 exactly while the output gate is closed, and `sd_clk` is 0 whenever `clk_off` is 1. `clk_off` falls in the cycle of the first rising edge of `sd_clk` after enabling. It rises within one period of a disable.
- R9: An applied field write clears `clk_stable` on the clock edge that takes the write. `clk_stable` sets again exactly two full output periods (4*P*D/2 base cycles) later, whether or not the output is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_clk_en | input | 1 | Card clock enable value written by the strobe |
| cfg_pre_sel | input | 8 | One-hot prescale select |
| cfg_div_sel | input | 4 | Divisor select, factor minus one |
| sd_clk | output | 1 | Gated card clock |
| clk_stable | output | 1 | Frequency has settled since the last applied field write |
| clk_off | output | 1 | Card clock output is held off |

## Verification
The bench measures every high pulse and full period at the extreme settings: the fastest setting of divide by 2, and the slowest of 256 times 16. A cascade that wrapped a counter one step late, or that decoded the prescale code as binary, would show periods off by whole prescaler steps. Invalid prescale codes are applied, and a decoder that let them through would produce divide by 12 or a stuck clock instead of divide by 2. The output is disabled in the middle of a high pulse, and that pulse must still reach full width; gating on the enable alone would leave a runt. Field writes are issued while the clock is running and while the gate is still draining. A design that accepted them would clear `clk_stable` and change the period.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
    // One-cycle events from the divider: internal phase about to go high / low
    typedef struct packed {
        logic rise;
        logic fall;
    } phase_evt_t;
endpackage

// File: rtl/sdclk_cfg.sv
module sdclk_cfg #(
    parameter int PRE_W = 8,
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             wr_en,
    input  logic [PRE_W-1:0] wr_pre,
    input  logic [DIV_W-1:0] wr_div,
    input  logic             gate_open,
    output logic             en,
    output logic [PRE_W-1:0] pre,
    output logic [DIV_W-1:0] div,
    output logic             load
);
    typedef struct packed {
        logic             en;
        logic [PRE_W-1:0] pre;
        logic [DIV_W-1:0] div;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic accept;

    always_comb begin
        cfg_d  = cfg_q;
        accept = wr && !cfg_q.en && !gate_open;
        if (wr) cfg_d.en = wr_en;
        if (accept) begin
            cfg_d.pre = wr_pre;
            cfg_d.div = wr_div;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.en  <= 1'b0;
            cfg_q.pre <= PRE_W'(1);
            cfg_q.div <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign en   = cfg_q.en;
    assign pre  = cfg_q.pre;
    assign div  = cfg_q.div;
    assign load = accept;

    // R6: writes while enabled or while the gate still drains leave the fields alone
    p_field_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (cfg_q.en || gate_open)) |=> ($stable(cfg_q.pre) && $stable(cfg_q.div)));
endmodule

// File: rtl/sdclk_divchain.sv
module sdclk_divchain
    import sdclk_pkg::*;
#(
    parameter int PRE_W = 8,
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PRE_W-1:0] pre,
    input  logic [DIV_W-1:0] div,
    output phase_evt_t       evt
);
    typedef struct packed {
        logic [PRE_W-1:0] pre_cnt;
        logic [DIV_W-1:0] div_cnt;
        logic             phase;
    } div_t;

    div_t dv_d, dv_q;
    logic [PRE_W-1:0] half_pre;   // prescale factor / 2 equals the one-hot code
    logic pre_wrap, toggle;

    always_comb begin
        half_pre = ($countones(pre) == 1) ? pre : PRE_W'(1);
        pre_wrap = (dv_q.pre_cnt == half_pre - PRE_W'(1));
        toggle   = pre_wrap && (dv_q.div_cnt == div);
        dv_d     = dv_q;
        if (load) begin
            dv_d = '0;
        end else begin
            dv_d.pre_cnt = pre_wrap ? '0 : dv_q.pre_cnt + 1'b1;
            if (pre_wrap)
                dv_d.div_cnt = (dv_q.div_cnt == div) ? '0 : dv_q.div_cnt + 1'b1;
            if (toggle)
                dv_d.phase = !dv_q.phase;
        end
        evt.rise = toggle && !load && !dv_q.phase;
        evt.fall = toggle && !load &&  dv_q.phase;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dv_q <= '0;
        else        dv_q <= dv_d;
    end

    // R2: the prescale counter never runs past its selected half factor
    p_pre_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dv_q.pre_cnt < half_pre);
    // R3: the divisor counter never runs past the selected divisor
    p_div_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dv_q.div_cnt <= div);
endmodule

// File: rtl/sdclk_outgate.sv
module sdclk_outgate
    import sdclk_pkg::*;
#(
    parameter int STABLE_PERIODS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       load,
    input  phase_evt_t evt,
    output logic       sd_clk,
    output logic       clk_off,
    output logic       stable
);
    localparam int SC_W = $clog2(STABLE_PERIODS + 1);

    typedef struct packed {
        logic            gate;
        logic            ck;
        logic [SC_W-1:0] scnt;
        logic            stable;
    } gate_t;

    gate_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        // gate decisions only at the low-to-high point of the internal phase
        if (evt.rise) begin
            g_d.gate = en;
            g_d.ck   = en;
        end else if (evt.fall) begin
            g_d.ck = 1'b0;
        end
        if (load) begin
            g_d.scnt   = '0;
            g_d.stable = 1'b0;
        end else if (evt.fall && (g_q.scnt != SC_W'(STABLE_PERIODS))) begin
            g_d.scnt   = g_q.scnt + 1'b1;
            g_d.stable = (g_q.scnt + 1'b1 == SC_W'(STABLE_PERIODS));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign sd_clk  = g_q.ck;
    assign clk_off = !g_q.gate;
    assign stable  = g_q.stable;

    // R8: a closed gate always means a low output
    p_off_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clk_off |-> !sd_clk);
    // R7: a rising output edge needs the enable in the cycle before
    p_rise_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sd_clk) |-> $past(en));
    // R7: a high pulse only ends on the divider's fall event
    p_high_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_clk && !evt.fall) |=> sd_clk);
    // R9: an applied field write clears the settled flag
    p_reload_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !stable);
endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
    import sdclk_pkg::*;
#(
    parameter int PRE_W          = 8,
    parameter int DIV_W          = 4,
    parameter int STABLE_PERIODS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_clk_en,
    input  logic [PRE_W-1:0] cfg_pre_sel,
    input  logic [DIV_W-1:0] cfg_div_sel,
    output logic             sd_clk,
    output logic             clk_stable,
    output logic             clk_off
);
    logic             en;
    logic [PRE_W-1:0] pre;
    logic [DIV_W-1:0] div;
    logic             load;
    phase_evt_t       evt;

    sdclk_cfg #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (cfg_wr),
        .wr_en     (cfg_clk_en),
        .wr_pre    (cfg_pre_sel),
        .wr_div    (cfg_div_sel),
        .gate_open (!clk_off),
        .en        (en),
        .pre       (pre),
        .div       (div),
        .load      (load)
    );

    sdclk_divchain #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .pre   (pre),
        .div   (div),
        .evt   (evt)
    );

    sdclk_outgate #(.STABLE_PERIODS(STABLE_PERIODS)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .load    (load),
        .evt     (evt),
        .sd_clk  (sd_clk),
        .clk_off (clk_off),
        .stable  (clk_stable)
    );
endmodule

// File: tb/tb_sdclk_gen.sv
module tb_sdclk_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic       cfg_clk_en = 1'b0;
    logic [7:0] cfg_pre_sel = 8'h01;
    logic [3:0] cfg_div_sel = 4'h0;
    logic       sd_clk, clk_stable, clk_off;

    int nchk = 0;
    int nfail = 0;
    int cur_h = 0;     // expected half period of the running clock
    int sb[$];         // scoreboard: expected half periods to measure
    bit done = 1'b0;

    always #5 clk = !clk;

    sdclk_gen dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_clk_en(cfg_clk_en),
        .cfg_pre_sel(cfg_pre_sel), .cfg_div_sel(cfg_div_sel),
        .sd_clk(sd_clk), .clk_stable(clk_stable), .clk_off(clk_off)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_half(input logic [7:0] p, input logic [3:0] d);
        int hp;
        hp = ($countones(p) == 1) ? int'(p) : 1;   // R2, R5
        return hp * (int'(d) + 1);                 // R3
    endfunction

    task automatic cfg_write(input bit en, input logic [7:0] p, input logic [3:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_clk_en = en; cfg_pre_sel = p; cfg_div_sel = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Scoreboard monitor: measures one full period for each queued item (R4)
    initial begin
        forever begin
            int hi, lo, e;
            wait (sb.size() != 0);
            e = sb[0];
            do @(negedge clk); while (sd_clk !== 1'b0);
            do @(negedge clk); while (sd_clk !== 1'b1);
            hi = 0;
            while (sd_clk === 1'b1) begin hi++; @(negedge clk); end
            lo = 0;
            while (sd_clk === 1'b0) begin lo++; @(negedge clk); end
            chk(hi == e, "R4 high time", hi, e);
            chk(lo == e, "R4 low time", lo, e);
            void'(sb.pop_front());
        end
    end

    // Pulse width monitor: every high pulse is full length (R7)
    initial begin
        int run;
        run = 0;
        forever begin
            @(negedge clk);
            if (rst_n && sd_clk === 1'b1) run++;
            else begin
                if (run != 0) chk(run == cur_h, "R7 pulse width", run, cur_h);
                run = 0;
            end
        end
    end

    // Full configure / settle / run / stop cycle for one setting
    task automatic run_cfg(input logic [7:0] p, input logic [3:0] d, input string tag);
        int h, cnt;
        bit prev_off, stayed_low;
        h = exp_half(p, d);
        cur_h = h;
        cfg_write(1'b0, p, d);
        chk(clk_stable == 1'b0, "R9 clear on write", clk_stable, 0);
        cnt = 0;
        while (!clk_stable && cnt < 20000) begin @(negedge clk); cnt++; end
        chk(cnt == 4 * h, "R9 settle time", cnt, 4 * h);
        cfg_write(1'b1, p, d);
        sb.push_back(h);
        prev_off = clk_off;
        cnt = 0;
        while (sd_clk !== 1'b1 && cnt < 20000) begin
            prev_off = clk_off; @(negedge clk); cnt++;
        end
        chk(prev_off == 1'b1 && clk_off == 1'b0, "R8 off falls with first edge",
            {prev_off, clk_off}, 2'b10);
        wait (sb.size() == 0);
        chk(cur_h == h, tag, cur_h, h);
        cfg_write(1'b0, p, d);
        cnt = 0;
        while (!clk_off && cnt < 2 * h + 4) begin @(negedge clk); cnt++; end
        chk(clk_off == 1'b1, "R8 off after disable", clk_off, 1);
        stayed_low = 1'b1;
        for (int i = 0; i < 2 * h + 2; i++) begin
            @(negedge clk);
            if (sd_clk !== 1'b0) stayed_low = 1'b0;
        end
        chk(stayed_low, "R7 stays low when disabled", stayed_low, 1);
    endtask

    // Watchdog
    initial begin
        for (int i = 0; i < 150000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL R4 watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int cnt;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(sd_clk == 1'b0 && clk_off == 1'b1 && clk_stable == 1'b0, "R1 reset state",
            {sd_clk, clk_off, clk_stable}, 3'b010);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(sd_clk == 1'b0 && clk_off == 1'b1, "R1 after reset", {sd_clk, clk_off}, 2'b01);

        run_cfg(8'h01, 4'd0,  "R2 divide by 2");
        run_cfg(8'h04, 4'd2,  "R2 R3 divide by 24");
        run_cfg(8'h02, 4'd4,  "R3 divide by 20");
        run_cfg(8'h06, 4'd1,  "R5 multi-bit code");
        run_cfg(8'h00, 4'd0,  "R5 zero code");
        run_cfg(8'h80, 4'd15, "R2 divide by 4096");

        // R6: field writes while running or while the gate drains are dropped
        cur_h = exp_half(8'h04, 4'd2);
        cfg_write(1'b0, 8'h04, 4'd2);
        cnt = 0;
        while (!clk_stable && cnt < 1000) begin @(negedge clk); cnt++; end
        cfg_write(1'b1, 8'h04, 4'd2);
        cnt = 0;
        while (!clk_stable && cnt < 1000) begin @(negedge clk); cnt++; end
        cfg_write(1'b1, 8'h01, 4'd0);
        chk(clk_stable == 1'b1, "R6 write while enabled", clk_stable, 1);
        sb.push_back(12);
        wait (sb.size() == 0);
        // disable mid high pulse, then write fields while the pulse drains
        cnt = 0;
        while (sd_clk !== 1'b1 && cnt < 100) begin @(negedge clk); cnt++; end
        @(negedge clk);
        cfg_write(1'b0, 8'h01, 4'd0);
        chk(clk_off == 1'b0, "R7 gate open while pulse drains", clk_off, 0);
        cfg_write(1'b0, 8'h01, 4'd0);
        chk(clk_stable == 1'b1, "R6 write while gate drains", clk_stable, 1);
        cnt = 0;
        while (!clk_off && cnt < 100) begin @(negedge clk); cnt++; end
        chk(clk_off == 1'b1 && sd_clk == 1'b0, "R8 off after drain", {clk_off, sd_clk}, 2'b10);
        chk(clk_stable == 1'b1, "R6 stable kept", clk_stable, 1);

        repeat (30) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule